// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the host-facing register access port of a small timekeeping peripheral. It sits between a byte-wide host bus and an internal byte-addressed register bank. The bus is made of a latched register address, a data-in and data-out pair with an output enable, a strobe pin, a direction or write pin, and a static mode pin. The mode pin selects one of two timing styles. In strobe style, one positive strobe qualifies every cycle, and a direction pin says whether the cycle is a read or a write. In enable style, the strobe pin becomes an active-low read enable and the direction pin becomes an active-low write enable.

Every host pin is brought into the system clock through a two-flop synchroniser, and all edge detection uses the synchronised copies. The bank holds general storage, one control byte and one read-only flag byte. Flags are set by event pulses from the timekeeping core. An active-low reset pin blocks all host access and stops the block from driving the data bus. While that pin is low, the block clears the interrupt enables, the square-wave enable and every flag. It does not touch the other control bits or the general storage.

Top module: `hbus_port`

## Requirements
- R1: With mode_i high, while strb_i is high and rw_i is high, dq_oe_o is high and dq_o carries the byte at addr_i. When strb_i returns low, dq_oe_o goes low.
- R2: With mode_i high, dq_i is written to addr_i on the falling edge of strb_i when rw_i was low during the strobe. A strobe taken with rw_i high writes nothing.
- R3: With mode_i low, dq_oe_o is high while strb_i is low, and dq_o carries the byte at addr_i.
- R4: With mode_i low, dq_i is written to addr_i on the rising edge of rw_i, which acts as an active-low write enable.
- R5: With mode_i low, a write whose rising edge occurs while strb_i is low is discarded.
- R6: While nrst_i is low, dq_oe_o stays low and host writes change nothing.
- R7: While nrst_i is low, control bits 6..4 (periodic, alarm and update-ended interrupt enables) and bit 3 (square-wave enable) are cleared, all flags are cleared, and irq_oe_o is low. Control bits 7 and 2..0 and general storage keep their values.
- R8: Address FLAG_ADDR reads {summary, periodic, alarm, update-ended, 4'b0}. evt_i[2], evt_i[1] and evt_i[0] set the periodic, alarm and update-ended flags. The summary bit is set when any flag has its enable set in the control byte, and irq_oe_o follows the summary bit. Host writes to the flag byte are ignored.
- R9: sqw_en_o follows control bit 3. The control byte is at address CTRL_ADDR.
- R10: After the synchronous system reset rst, dq_oe_o, irq_oe_o and sqw_en_o are low and the control byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| mode_i | input | 1 | Static bus style: 1 strobe style, 0 enable style |
| strb_i | input | 1 | Data strobe (strobe style) or active-low read enable |
| rw_i | input | 1 | Direction, 1 read (strobe style), or active-low write enable |
| nrst_i | input | 1 | Active-low access-blocking reset pin |
| addr_i | input | ADDR_W | Latched register address |
| dq_i | input | 8 | Host write data |
| dq_o | output | 8 | Read data towards host |
| dq_oe_o | output | 1 | Read data output enable |
| evt_i | input | 3 | Core event pulses: periodic, alarm, update-ended |
| irq_oe_o | output | 1 | Drive enable of the open-drain interrupt pin |
| sqw_en_o | output | 1 | Square-wave enable |

## Verification
Storage is written and read back in both bus styles. This separates a write taken on the trailing strobe edge from one taken on the rising write edge. It also shows that read drive follows the correct pin polarity in each style. A write pulse that overlaps an active read enable is aimed at a location that already holds a known value, so a wrongly accepted write shows up as a changed byte. A reset-pin window holds a full read attempt and a write attempt, and afterwards a control byte of all ones must come back with only the enable bits cleared. Events are raised once with their enable set and once without it, which separates the flag bits from the summary bit and from the interrupt drive.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DATA_W = 8;
  // control byte bit positions
  localparam int EN_PER = 6;
  localparam int EN_ALM = 5;
  localparam int EN_UPD = 4;
  localparam int EN_SQW = 3;
  // event vector positions
  localparam int EV_PER = 2;
  localparam int EV_ALM = 1;
  localparam int EV_UPD = 0;

  typedef enum logic {
    MODE_ENABLE = 1'b0,
    MODE_STROBE = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } flags_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_s,
  input  logic strb_s,
  input  logic rw_s,
  input  logic nrst_s,
  output logic wr_stb,
  output logic rd_act
);
  localparam int ARM_CNT = STAGES + 1;
  localparam int CNT_W   = $clog2(ARM_CNT + 1);

  logic [CNT_W-1:0] arm_cnt;
  logic             armed;
  logic             strb_d, rw_d, rw_hold;
  logic             strobe_fall, wen_rise;
  bus_mode_e        mode;

  assign mode = bus_mode_e'(mode_s);

  // edges are trusted only once the synchroniser holds real pin values
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt <= '0;
      armed   <= 1'b0;
    end else if (!armed) begin
      arm_cnt <= arm_cnt + 1'b1;
      armed   <= (arm_cnt == CNT_W'(ARM_CNT - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_d  <= 1'b0;
      rw_d    <= 1'b1;
      rw_hold <= 1'b1;
    end else begin
      strb_d <= strb_s;
      rw_d   <= rw_s;
      if (strb_s) rw_hold <= rw_s;
    end
  end

  assign strobe_fall = strb_d & ~strb_s;
  assign wen_rise    = ~rw_d & rw_s;

  always_comb begin
    wr_stb = 1'b0;
    rd_act = 1'b0;
    if (nrst_s) begin
      if (mode == MODE_STROBE) begin
        rd_act = strb_s & rw_s;
        wr_stb = armed & strobe_fall & ~rw_hold;
      end else begin
        rd_act = ~strb_s;
        wr_stb = armed & wen_rise & strb_s;
      end
    end
  end
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
  import hbus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CTRL_ADDR = 11,
  parameter int FLAG_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nrst_s,
  input  logic              wr_stb,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic [2:0]        evt,
  output logic [DATA_W-1:0] rdata,
  output logic              oe,
  output logic              irq_oe,
  output logic              sqw_en,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q, ctrl_q, flag_byte;
  logic [ADDR_W-1:0] addr_q;
  flags_t            flags_q;
  logic              summary;

  // general storage, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_stb) mem[addr_s] <= wdata_s;
    ram_q <= mem[addr_s];
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (!nrst_s) begin
      ctrl_q[EN_PER] <= 1'b0;
      ctrl_q[EN_ALM] <= 1'b0;
      ctrl_q[EN_UPD] <= 1'b0;
      ctrl_q[EN_SQW] <= 1'b0;
    end else if (wr_stb && addr_s == A_CTRL) begin
      ctrl_q <= wdata_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !nrst_s) begin
      flags_q <= '0;
    end else begin
      flags_q.per <= flags_q.per | evt[EV_PER];
      flags_q.alm <= flags_q.alm | evt[EV_ALM];
      flags_q.upd <= flags_q.upd | evt[EV_UPD];
    end
  end

  assign summary = (flags_q.per & ctrl_q[EN_PER]) |
                   (flags_q.alm & ctrl_q[EN_ALM]) |
                   (flags_q.upd & ctrl_q[EN_UPD]);
  assign flag_byte = {summary, flags_q.per, flags_q.alm, flags_q.upd, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      oe     <= 1'b0;
      irq_oe <= 1'b0;
      sqw_en <= 1'b0;
    end else begin
      if (addr_q == A_CTRL)      rdata <= ctrl_q;
      else if (addr_q == A_FLAG) rdata <= flag_byte;
      else                       rdata <= ram_q;
      oe     <= rd_act;
      irq_oe <= nrst_s & summary;
      sqw_en <= ctrl_q[EN_SQW];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/hbus_port.sv
module hbus_port
  import hbus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CTRL_ADDR = 11,
  parameter int FLAG_ADDR = 12,
  parameter int STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              strb_i,
  input  logic              rw_i,
  input  logic              nrst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [2:0]        evt_i,
  output logic              irq_oe_o,
  output logic              sqw_en_o
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [3:0]        ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              mode_s, strb_s, rw_s, nrst_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;
  logic              wr_stb, rd_act;
  logic [DATA_W-1:0] ctrl_byte;

  hbus_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b0010)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({mode_i, strb_i, rw_i, nrst_i}),
    .q(ctl_s)
  );

  hbus_sync #(.W(BUS_W), .STAGES(STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst),
    .d({addr_i, dq_i}),
    .q(bus_s)
  );

  assign {mode_s, strb_s, rw_s, nrst_s} = ctl_s;
  assign {addr_s, wdata_s}              = bus_s;

  hbus_decode #(.STAGES(STAGES)) u_dec (
    .clk(clk), .rst(rst),
    .mode_s(mode_s), .strb_s(strb_s), .rw_s(rw_s), .nrst_s(nrst_s),
    .wr_stb(wr_stb), .rd_act(rd_act)
  );

  hbus_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .nrst_s(nrst_s),
    .wr_stb(wr_stb), .rd_act(rd_act),
    .addr_s(addr_s), .wdata_s(wdata_s), .evt(evt_i),
    .rdata(dq_o), .oe(dq_oe_o), .irq_oe(irq_oe_o), .sqw_en(sqw_en_o),
    .ctrl_o(ctrl_byte)
  );
endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       nrst_s,
  input logic       rd_act,
  input logic       dq_oe_o,
  input logic       irq_oe_o,
  input logic       sqw_en_o,
  input logic [7:0] ctrl_byte
);
  // R6: the reset pin stops the read drive
  a_r6_no_drive: assert property (@(posedge clk) disable iff (rst)
    !nrst_s |=> !dq_oe_o);

  // R7: interrupt drive released while the reset pin is low
  a_r7_irq_released: assert property (@(posedge clk) disable iff (rst)
    !nrst_s |=> !irq_oe_o);

  // R7: square-wave enable dropped two cycles after the pin is seen low
  a_r7_sqw_cleared: assert property (@(posedge clk) disable iff (rst)
    !nrst_s |-> ##2 !sqw_en_o);

  // R7: control bits outside the enables survive the reset pin
  a_r7_keep_bits: assert property (@(posedge clk) disable iff (rst)
    !nrst_s |=> ctrl_byte[2:0] == $past(ctrl_byte[2:0]) && ctrl_byte[7] == $past(ctrl_byte[7]));

  // R1: drive only follows a decoded read
  a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> $past(rd_act));
endmodule

bind hbus_port hbus_port_chk u_chk (
  .clk(clk), .rst(rst), .nrst_s(nrst_s), .rd_act(rd_act),
  .dq_oe_o(dq_oe_o), .irq_oe_o(irq_oe_o), .sqw_en_o(sqw_en_o),
  .ctrl_byte(ctrl_byte)
);

// File: tb/sim_hbus_port.sv
`timescale 1ns/1ps
module sim_hbus_port;
  localparam int AW = 6;
  localparam logic [AW-1:0] CTRL = 6'd11;
  localparam logic [AW-1:0] FLAG = 6'd12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i = 1'b1, strb_i = 1'b0, rw_i = 1'b1, nrst_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] dq_i = '0, dq_o;
  logic dq_oe_o, irq_oe_o, sqw_en_o;
  logic [2:0] evt_i = '0;

  int vectors = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  hbus_port u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .strb_i(strb_i), .rw_i(rw_i),
    .nrst_i(nrst_i), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .evt_i(evt_i), .irq_oe_o(irq_oe_o), .sqw_en_o(sqw_en_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every rise of the output enable consumes one expected byte
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (dq_oe_o && !prev_oe) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected drive actual=%h expected=no drive", dq_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (dq_o !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, dq_o, e);
        end
      end
    end
    prev_oe = dq_oe_o;
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    addr_i = a; dq_i = d;
    if (mode_i) begin
      rw_i = 1'b0; idle(3);
      strb_i = 1'b1; idle(6);
      strb_i = 1'b0; idle(6);
      rw_i = 1'b1; idle(2);
    end else begin
      idle(3);
      rw_i = 1'b0; idle(6);
      rw_i = 1'b1; idle(8);
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [7:0] e, input string tag,
                          input bit expect_drive);
    addr_i = a; idle(6);
    if (expect_drive) begin exp_q.push_back(e); tag_q.push_back(tag); end
    if (mode_i) begin
      rw_i = 1'b1; strb_i = 1'b1; idle(8);
      strb_i = 1'b0;
    end else begin
      strb_i = 1'b0; idle(8);
      strb_i = 1'b1;
    end
    idle(5);
    check({tag, " oe released"}, {7'd0, dq_oe_o}, 8'h00);
    check({tag, " queue drained"}, 8'(exp_q.size()), 8'h00);
  endtask

  task automatic pulse_evt(input logic [2:0] v);
    @(negedge clk) evt_i = v;
    @(negedge clk) evt_i = '0;
    idle(3);
  endtask

  task automatic sys_reset(input logic mode, input logic strb_idle);
    rst = 1'b1; mode_i = mode; strb_i = strb_idle; rw_i = 1'b1;
    idle(5); rst = 1'b0; idle(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // strobe style
    sys_reset(1'b1, 1'b0);
    check("R10 oe after reset", {7'd0, dq_oe_o}, 8'h00);
    check("R10 irq after reset", {7'd0, irq_oe_o}, 8'h00);
    check("R10 sqw after reset", {7'd0, sqw_en_o}, 8'h00);
    bus_read(CTRL, 8'h00, "R10 ctrl after reset", 1'b1);

    bus_write(6'h05, 8'hA5);
    bus_write(6'h2A, 8'h3C);
    bus_read(6'h05, 8'hA5, "R2/R1 addr05", 1'b1);
    bus_read(6'h2A, 8'h3C, "R2/R1 addr2A", 1'b1);
    bus_read(6'h05, 8'hA5, "R2 read strobe wrote nothing", 1'b1);

    bus_write(CTRL, 8'hFF);
    check("R9 sqw set", {7'd0, sqw_en_o}, 8'h01);
    bus_read(CTRL, 8'hFF, "R9 ctrl readback", 1'b1);
    pulse_evt(3'b100);
    check("R8 irq with enable", {7'd0, irq_oe_o}, 8'h01);
    bus_read(FLAG, 8'hC0, "R8 periodic flag", 1'b1);
    bus_write(FLAG, 8'h00);
    bus_read(FLAG, 8'hC0, "R8 flag write ignored", 1'b1);

    // reset pin window
    nrst_i = 1'b0; idle(6);
    check("R7 irq released", {7'd0, irq_oe_o}, 8'h00);
    check("R7 sqw cleared", {7'd0, sqw_en_o}, 8'h00);
    bus_read(6'h05, 8'h00, "R6 read blocked", 1'b0);
    bus_write(6'h05, 8'h11);
    nrst_i = 1'b1; idle(6);
    bus_read(CTRL, 8'h87, "R7 ctrl enables cleared", 1'b1);
    bus_read(FLAG, 8'h00, "R7 flags cleared", 1'b1);
    bus_read(6'h05, 8'hA5, "R6/R7 storage kept", 1'b1);

    // enable style
    sys_reset(1'b0, 1'b1);
    bus_write(6'h10, 8'h5A);
    bus_read(6'h10, 8'h5A, "R4/R3 addr10", 1'b1);
    // write edge while read enable is low must be dropped
    addr_i = 6'h10; dq_i = 8'hFF; idle(6);
    exp_q.push_back(8'h5A); tag_q.push_back("R5 overlap read");
    strb_i = 1'b0; idle(3);
    rw_i = 1'b0; idle(4);
    rw_i = 1'b1; idle(6);
    strb_i = 1'b1; idle(6);
    bus_read(6'h10, 8'h5A, "R5 overlapped write dropped", 1'b1);

    bus_write(CTRL, 8'h10);
    check("R9 sqw clear", {7'd0, sqw_en_o}, 8'h00);
    pulse_evt(3'b010);
    check("R8 irq without enable", {7'd0, irq_oe_o}, 8'h00);
    bus_read(FLAG, 8'h20, "R8 alarm flag no summary", 1'b1);
    pulse_evt(3'b001);
    check("R8 irq update enabled", {7'd0, irq_oe_o}, 8'h01);
    bus_read(FLAG, 8'hB0, "R8 update flag summary", 1'b1);

    sys_reset(1'b0, 1'b1);
    check("R10 irq after second reset", {7'd0, irq_oe_o}, 8'h00);
    bus_read(CTRL, 8'h00, "R10 ctrl cleared", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule